// File: doc/BRIEF.md
# Triggered Memory-Bus Fault Injector

This block sits between a simple processor and its memory. The bus carries an address, read data, write data and three strobes: fetch, load and store. Software loads a trigger condition, a target word, a bit mask, a fault operation and a persistence mode through a small register port. After that it arms the injector. Until the trigger fires, every bus transfer passes through unchanged.

Once the trigger fires, transfers that touch the target word are corrupted. Read data is corrupted on a fetch or a load. Write data is corrupted on a store. The corruption is combinational, so the bus path adds no latency.

The trigger can be one of four kinds: an instruction fetch from a given address, a data load from a given address, a store to a given address, or a given cycle count since reset. The persistence mode sets how often the fault is applied. A transient fault hits a single access. A permanent fault hits every access. An intermittent fault hits only those accesses for which a pseudo-random sequence says so.

Top module: `fault_injector`

## Requirements
- R1: After reset the status register (address 6) reads zero, and every bus transfer passes through unchanged.
- R2: Trigger kind 0 fires on a fetch whose address equals the trigger address (register 1). The sticky fired flag (status bit 0) is set from the next cycle. Corruption starts with the first target access after the firing cycle.
- R3: Trigger kind 1 fires only on a load strobe and kind 2 fires only on a store strobe, each at the trigger address. Another strobe at that address leaves the injector unfired.
- R4: Trigger kind 3 fires in the cycle in which the cycle counter equals register 2. The counter is 0 in the first cycle after reset and increases by one every cycle.
- R5: The fault operation is CTRL bits [3:2]. Code 0 clears the masked bits, code 1 sets them, and codes 2 and 3 invert them. Fetches and loads have the read data corrupted. Stores have the write data corrupted.
- R6: The mask (register 4) is applied bit for bit. Single-bit, two-bit, single-byte and multi-byte masks each change exactly the selected bits.
- R7: Persistence code 0 (CTRL bits [5:4]) corrupts exactly one access to the target word (register 3). After that the fault is inactive (status bit 2 clear).
- R8: Persistence codes 2 and 3 corrupt every later access to the target word until a clear command.
- R9: Persistence code 1 corrupts a target access only when bit 0 of a 16-bit LFSR is 1. The LFSR then steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. It is loaded from the seed register (register 5) when the injector is armed, and a zero seed is replaced by 1.
- R10: Accesses to other addresses, and all accesses before the trigger fires, pass through with zero latency. This includes the triggering access itself.
- R11: Status bits [16+:CNT_W] count the corrupted accesses and saturate at their maximum. The fired flag stays set until cleared.
- R12: Writing CTRL with bit 9 set clears the fired, armed and active flags and the counter. Writing CTRL with bit 8 set arms the trigger. CTRL bits [1:0] select the trigger kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_addr | input | AW | Bus address |
| bus_fetch | input | 1 | Instruction fetch strobe |
| bus_load | input | 1 | Data load strobe |
| bus_store | input | 1 | Data store strobe |
| mem_rdata | input | DW | Read data from memory |
| cpu_rdata | output | DW | Read data delivered to the processor |
| cpu_wdata | input | DW | Write data from the processor |
| mem_wdata | output | DW | Write data delivered to memory |

## Verification
The assertions check on every cycle that:
- untargeted or inactive transfers pass through unchanged;
- a transient fault goes inactive after its one hit;
- a permanent fault stays active;
- the fired flag is sticky;
- the counter never steps by more than one;
- a clear empties the state;
- set-mode corruption leaves every masked bit high.

Only the bench scenarios can show the remaining behaviour: the exact trigger timing for each of the four kinds, the values produced by each operation and mask, the LFSR-selected pattern of intermittent hits, and counter saturation.

// File: rtl/fi_pkg.sv
package fi_pkg;

    localparam int LFSR_W   = 16;
    localparam int CFG_W    = 32;
    localparam int CFG_AW   = 3;

    localparam logic [CFG_AW-1:0] REG_CTRL   = 3'd0;
    localparam logic [CFG_AW-1:0] REG_TADDR  = 3'd1;
    localparam logic [CFG_AW-1:0] REG_TCYC   = 3'd2;
    localparam logic [CFG_AW-1:0] REG_TARGET = 3'd3;
    localparam logic [CFG_AW-1:0] REG_MASK   = 3'd4;
    localparam logic [CFG_AW-1:0] REG_SEED   = 3'd5;
    localparam logic [CFG_AW-1:0] REG_STATUS = 3'd6;

    localparam int CTRL_ARM_BIT   = 8;
    localparam int CTRL_CLEAR_BIT = 9;

    typedef enum logic [1:0] {
        TRG_FETCH = 2'd0,
        TRG_LOAD  = 2'd1,
        TRG_STORE = 2'd2,
        TRG_CYCLE = 2'd3
    } trig_kind_e;

    typedef enum logic [1:0] {
        OP_CLR      = 2'd0,
        OP_SET      = 2'd1,
        OP_FLIP     = 2'd2,
        OP_FLIP_ALT = 2'd3
    } fault_op_e;

    typedef enum logic [1:0] {
        PER_ONCE      = 2'd0,
        PER_RANDOM    = 2'd1,
        PER_STUCK     = 2'd2,
        PER_STUCK_ALT = 2'd3
    } persist_e;

    typedef struct packed {
        persist_e   persist;
        fault_op_e  op;
        trig_kind_e kind;
    } fault_mode_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic is_stuck(input persist_e p);
        return (p == PER_STUCK) || (p == PER_STUCK_ALT);
    endfunction

endpackage

// File: rtl/fi_cfg_regs.sv
module fi_cfg_regs
    import fi_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CYC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 fired,
    input  logic                 armed,
    input  logic                 active,
    input  logic [CNT_W-1:0]     inj_count,
    output fault_mode_t          mode,
    output logic [AW-1:0]        trig_addr,
    output logic [CYC_W-1:0]     trig_cycle,
    output logic [AW-1:0]        target_addr,
    output logic [DW-1:0]        mask,
    output logic [LFSR_W-1:0]    seed,
    output logic                 arm_pulse,
    output logic                 clear_pulse
);

    logic ctrl_wr;
    logic unused_wbits;

    assign ctrl_wr      = cfg_we && (cfg_addr == REG_CTRL);
    assign arm_pulse    = ctrl_wr && cfg_wdata[CTRL_ARM_BIT];
    assign clear_pulse  = ctrl_wr && cfg_wdata[CTRL_CLEAR_BIT];
    assign unused_wbits = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= '0;
            trig_addr   <= '0;
            trig_cycle  <= '0;
            target_addr <= '0;
            mask        <= '0;
            seed        <= LFSR_W'(1);
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL:   mode        <= fault_mode_t'(cfg_wdata[5:0]);
                REG_TADDR:  trig_addr   <= cfg_wdata[AW-1:0];
                REG_TCYC:   trig_cycle  <= cfg_wdata[CYC_W-1:0];
                REG_TARGET: target_addr <= cfg_wdata[AW-1:0];
                REG_MASK:   mask        <= cfg_wdata[DW-1:0];
                REG_SEED:   seed        <= cfg_wdata[LFSR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL:   cfg_rdata[5:0]          = mode;
            REG_TADDR:  cfg_rdata[AW-1:0]       = trig_addr;
            REG_TCYC:   cfg_rdata[CYC_W-1:0]    = trig_cycle;
            REG_TARGET: cfg_rdata[AW-1:0]       = target_addr;
            REG_MASK:   cfg_rdata[DW-1:0]       = mask;
            REG_SEED:   cfg_rdata[LFSR_W-1:0]   = seed;
            REG_STATUS: begin
                cfg_rdata[0]          = fired;
                cfg_rdata[1]          = armed;
                cfg_rdata[2]          = active;
                cfg_rdata[16 +: CNT_W] = inj_count;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fi_trigger.sv
module fi_trigger
    import fi_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  trig_kind_e       kind,
    input  logic [AW-1:0]    trig_addr,
    input  logic [CYC_W-1:0] trig_cycle,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_fetch,
    input  logic             bus_load,
    input  logic             bus_store,
    output logic             hit
);

    logic [CYC_W-1:0] cyc_cnt;
    logic             addr_eq;

    always_ff @(posedge clk) begin
        if (rst) cyc_cnt <= '0;
        else     cyc_cnt <= cyc_cnt + CYC_W'(1);
    end

    assign addr_eq = (bus_addr == trig_addr);

    always_comb begin
        unique case (kind)
            TRG_FETCH: hit = bus_fetch && addr_eq;
            TRG_LOAD:  hit = bus_load  && addr_eq;
            TRG_STORE: hit = bus_store && addr_eq;
            TRG_CYCLE: hit = (cyc_cnt == trig_cycle);
        endcase
    end

endmodule

// File: rtl/fi_engine.sv
module fi_engine
    import fi_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              arm_pulse,
    input  logic              clear_pulse,
    input  fault_mode_t       mode,
    input  logic [AW-1:0]     target_addr,
    input  logic [DW-1:0]     mask,
    input  logic [LFSR_W-1:0] seed,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_fetch,
    input  logic              bus_load,
    input  logic              bus_store,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic [DW-1:0]     mem_wdata,
    output logic              fired,
    output logic              armed,
    output logic              active,
    output logic [CNT_W-1:0]  inj_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [LFSR_W-1:0] lfsr;
    logic              tgt_acc;
    logic              rand_ok;
    logic              apply;

    function automatic logic [DW-1:0] corrupt(input logic [DW-1:0] d,
                                              input logic [DW-1:0] m,
                                              input fault_op_e op);
        unique case (op)
            OP_CLR:  return d & ~m;
            OP_SET:  return d | m;
            default: return d ^ m;
        endcase
    endfunction

    assign tgt_acc = (bus_fetch || bus_load || bus_store) && (bus_addr == target_addr);
    assign rand_ok = (mode.persist != PER_RANDOM) || lfsr[0];
    assign apply   = active && tgt_acc && rand_ok;

    assign cpu_rdata = (apply && (bus_fetch || bus_load)) ? corrupt(mem_rdata, mask, mode.op) : mem_rdata;
    assign mem_wdata = (apply && bus_store) ? corrupt(cpu_wdata, mask, mode.op) : cpu_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            fired     <= 1'b0;
            armed     <= 1'b0;
            active    <= 1'b0;
            inj_count <= '0;
            lfsr      <= LFSR_W'(1);
        end else if (clear_pulse) begin
            fired     <= 1'b0;
            armed     <= 1'b0;
            active    <= 1'b0;
            inj_count <= '0;
        end else if (arm_pulse) begin
            armed  <= 1'b1;
            active <= 1'b0;
            lfsr   <= (seed == '0) ? LFSR_W'(1) : seed;
        end else begin
            if (armed && hit) begin
                armed  <= 1'b0;
                active <= 1'b1;
                fired  <= 1'b1;
            end
            if (active && tgt_acc) begin
                if (mode.persist == PER_RANDOM) lfsr   <= lfsr_step(lfsr);
                if (mode.persist == PER_ONCE)   active <= 1'b0;
            end
            if (apply && (inj_count != CNT_MAX)) inj_count <= inj_count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fault_injector.sv
module fault_injector
    import fi_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CYC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_fetch,
    input  logic              bus_load,
    input  logic              bus_store,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     mem_wdata
);

    fault_mode_t       mode;
    logic [AW-1:0]     trig_addr;
    logic [CYC_W-1:0]  trig_cycle;
    logic [AW-1:0]     target_addr;
    logic [DW-1:0]     mask;
    logic [LFSR_W-1:0] seed;
    logic              arm_pulse;
    logic              clear_pulse;
    logic              hit;
    logic              fired;
    logic              armed;
    logic              active;
    logic [CNT_W-1:0]  inj_count;

    fi_cfg_regs #(.AW(AW), .DW(DW), .CYC_W(CYC_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fired(fired), .armed(armed), .active(active), .inj_count(inj_count),
        .mode(mode), .trig_addr(trig_addr), .trig_cycle(trig_cycle),
        .target_addr(target_addr), .mask(mask), .seed(seed),
        .arm_pulse(arm_pulse), .clear_pulse(clear_pulse)
    );

    fi_trigger #(.AW(AW), .CYC_W(CYC_W)) u_trig (
        .clk(clk), .rst(rst), .kind(mode.kind),
        .trig_addr(trig_addr), .trig_cycle(trig_cycle),
        .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_load(bus_load), .bus_store(bus_store),
        .hit(hit)
    );

    fi_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .hit(hit),
        .arm_pulse(arm_pulse), .clear_pulse(clear_pulse),
        .mode(mode), .target_addr(target_addr), .mask(mask), .seed(seed),
        .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_load(bus_load), .bus_store(bus_store),
        .mem_rdata(mem_rdata), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .mem_wdata(mem_wdata),
        .fired(fired), .armed(armed), .active(active), .inj_count(inj_count)
    );

endmodule

// File: rtl/fi_checker.sv
module fi_checker
    import fi_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_fetch,
    input logic             bus_load,
    input logic             bus_store,
    input logic [DW-1:0]    mem_rdata,
    input logic [DW-1:0]    cpu_rdata,
    input logic [DW-1:0]    cpu_wdata,
    input logic [DW-1:0]    mem_wdata,
    input logic [AW-1:0]    target_addr,
    input logic [DW-1:0]    mask,
    input fault_mode_t      mode,
    input logic             arm_pulse,
    input logic             clear_pulse,
    input logic             fired,
    input logic             armed,
    input logic             active,
    input logic [CNT_W-1:0] inj_count
);

    logic tgt;
    assign tgt = (bus_fetch || bus_load || bus_store) && (bus_addr == target_addr);

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        !(active && tgt) |-> (cpu_rdata == mem_rdata) && (mem_wdata == cpu_wdata));

    p_once_r7: assert property (@(posedge clk) disable iff (rst)
        (active && tgt && mode.persist == PER_ONCE && !clear_pulse && !arm_pulse) |=> !active);

    p_stuck_r8: assert property (@(posedge clk) disable iff (rst)
        (active && is_stuck(mode.persist) && !clear_pulse && !arm_pulse) |=> active);

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (fired && !clear_pulse) |=> fired);

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        !clear_pulse |=> (inj_count == $past(inj_count)) || (inj_count == $past(inj_count) + CNT_W'(1)));

    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> !fired && !armed && !active && (inj_count == '0));

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        (active && tgt && bus_load && mode.op == OP_SET && mode.persist != PER_RANDOM)
            |-> ((cpu_rdata & mask) == mask));

endmodule

bind fault_injector fi_checker #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_fi_chk (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_load(bus_load), .bus_store(bus_store),
    .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata), .cpu_wdata(cpu_wdata), .mem_wdata(mem_wdata),
    .target_addr(target_addr), .mask(mask), .mode(mode),
    .arm_pulse(arm_pulse), .clear_pulse(clear_pulse),
    .fired(fired), .armed(armed), .active(active), .inj_count(inj_count)
);

// File: tb/tb_fault_injector.sv
`timescale 1ns/1ps
module tb_fault_injector;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] bus_addr = '0;
    logic        bus_fetch = 1'b0, bus_load = 1'b0, bus_store = 1'b0;
    logic [31:0] mem_rdata = '0, cpu_rdata, cpu_wdata = '0, mem_wdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] bc = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) bc <= '0;
        else     bc <= bc + 1;
    end

    fault_injector #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_load(bus_load),
        .bus_store(bus_store), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
        .cpu_wdata(cpu_wdata), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); cfg_addr = a; #1 v = cfg_rdata;
    endtask

    // kind: 0 fetch, 1 load, 2 store
    task automatic acc(input int kind, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] got);
        @(negedge clk);
        bus_addr = a; mem_rdata = d; cpu_wdata = d;
        bus_fetch = (kind == 0); bus_load = (kind == 1); bus_store = (kind == 2);
        #1 got = (kind == 2) ? mem_wdata : cpu_rdata;
        @(negedge clk);
        bus_fetch = 1'b0; bus_load = 1'b0; bus_store = 1'b0;
    endtask

    function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] m, input int op);
        if (op == 0) return d & ~m;
        if (op == 1) return d | m;
        return d ^ m;
    endfunction

    function automatic logic [31:0] ctrl(input int kind, input int op, input int per);
        return 32'h100 | 32'(kind) | (32'(op) << 2) | (32'(per) << 4);
    endfunction

    localparam logic [31:0] CLR = 32'h200;

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, g;
        logic [31:0] masks [4];
        masks[0] = 32'h0000_0010; masks[1] = 32'h8000_0001;
        masks[2] = 32'h0000_FF00; masks[3] = 32'h00FF_FF00;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd6, v); chk("R1 status after reset", v, 32'h0);
        acc(1, 32'h200, 32'hDEAD_BEEF, g); chk("R1 load passes", g, 32'hDEAD_BEEF);

        // R5 R6 R8 R3 sweep: load trigger, permanent
        for (int op = 0; op < 4; op++) begin
            for (int mi = 0; mi < 4; mi++) begin
                logic [31:0] d;
                d = 32'hA5C3_0F96 ^ (32'(op) << 8) ^ 32'(mi);
                wr(3'd0, CLR);
                wr(3'd4, masks[mi]);
                wr(3'd1, 32'h100);
                wr(3'd3, 32'h200);
                wr(3'd0, ctrl(1, op, 2));
                acc(1, 32'h200, d, g); chk("R10 before fire", g, d);
                acc(1, 32'h100, d, g); chk("R10 trigger access", g, d);
                acc(1, 32'h200, d, g); chk("R5 R6 load corrupt", g, model(d, masks[mi], op));
                acc(2, 32'h200, ~d, g); chk("R5 store corrupt", g, model(~d, masks[mi], op));
                acc(0, 32'h200, d, g); chk("R8 fetch again", g, model(d, masks[mi], op));
                acc(0, 32'h204, d, g); chk("R10 other addr", g, d);
                rd(3'd6, v); chk("R11 status count", v, 32'h0003_0005);
            end
        end

        // R2 fetch trigger, R7 transient
        wr(3'd0, CLR);
        wr(3'd1, 32'h40); wr(3'd3, 32'h300); wr(3'd4, 32'h1);
        wr(3'd0, ctrl(0, 2, 0));
        acc(1, 32'h40, 32'h0, g);
        acc(0, 32'h44, 32'h0, g);
        rd(3'd6, v); chk("R2 no fire on load or other fetch", v, 32'h2);
        acc(0, 32'h40, 32'h0, g);
        rd(3'd6, v); chk("R2 fired active", v, 32'h5);
        acc(1, 32'h300, 32'h1234_5678, g); chk("R7 first hit", g, 32'h1234_5679);
        acc(1, 32'h300, 32'h1234_5678, g); chk("R7 second passes", g, 32'h1234_5678);
        rd(3'd6, v); chk("R7 inactive count1", v, 32'h0001_0001);

        // R3 store trigger
        wr(3'd0, CLR);
        wr(3'd1, 32'h80); wr(3'd3, 32'h500); wr(3'd4, 32'hF000_0000);
        wr(3'd0, ctrl(2, 1, 2));
        acc(1, 32'h80, 32'h0, g);
        acc(0, 32'h80, 32'h0, g);
        rd(3'd6, v); chk("R3 load/fetch do not fire store kind", v, 32'h2);
        acc(2, 32'h80, 32'h0, g);
        rd(3'd6, v); chk("R3 store fires", v, 32'h5);
        acc(0, 32'h500, 32'h0000_0011, g); chk("R3 fault after store trigger", g, 32'hF000_0011);

        // R4 cycle trigger
        wr(3'd0, CLR);
        wr(3'd3, 32'h600); wr(3'd4, 32'h0000_00FF);
        @(negedge clk); v = bc + 32'd40;
        wr(3'd2, v);
        wr(3'd0, ctrl(3, 0, 2));
        @(negedge clk);
        while (bc != v) @(negedge clk);
        cfg_addr = 3'd6; #1 chk("R4 not yet fired", cfg_rdata & 32'h1, 32'h0);
        @(negedge clk); #1 chk("R4 fired next cycle", cfg_rdata & 32'h1, 32'h1);
        acc(1, 32'h600, 32'hFFFF_FFFF, g); chk("R4 clear op applied", g, 32'hFFFF_FF00);

        // R9 intermittent
        begin
            logic [15:0] l;
            int n;
            wr(3'd0, CLR);
            wr(3'd5, 32'hACE1); wr(3'd1, 32'h10); wr(3'd3, 32'h20); wr(3'd4, 32'hFF);
            wr(3'd0, ctrl(1, 2, 1));
            acc(1, 32'h10, 32'h0, g);
            l = 16'hACE1; n = 0;
            for (int i = 0; i < 24; i++) begin
                acc(1, 32'h20, 32'h5500, g);
                chk("R9 intermittent hit", g, l[0] ? 32'h55FF : 32'h5500);
                if (l[0]) n++;
                l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
            end
            rd(3'd6, v); chk("R9 count", v, (32'(n) << 16) | 32'h5);
        end

        // R11 saturation
        wr(3'd0, CLR);
        wr(3'd1, 32'h10); wr(3'd3, 32'h20); wr(3'd4, 32'h1);
        wr(3'd0, ctrl(1, 1, 3));
        acc(1, 32'h10, 32'h0, g);
        for (int i = 0; i < 300; i++) acc(1, 32'h20, 32'h0, g);
        rd(3'd6, v); chk("R11 saturated count", v, 32'h00FF_0005);

        // R12 clear
        wr(3'd0, CLR);
        rd(3'd6, v); chk("R12 cleared status", v, 32'h0);
        acc(1, 32'h20, 32'h0, g); chk("R12 no fault after clear", g, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule